// File: doc/BRIEF.md
# ALU Extra-Move Sequencer

This block sits beside the issue stage of a small microcoded processor. An ALU instruction may carry a two-bit modifier that asks for up to three extra register moves after the main operation. The sequencer takes that modifier, the decoded destination index, the second-source value and the live remaining-count register. It clips the request to the remaining count, then issues the moves one at a time through a valid/ready handshake. While a burst is pending it holds the issue stage off.

Each move carries a destination index and the captured second-source value. A destination in the special range selects which register each move writes. For that range, short bursts write only the data port. A three-move burst writes the data port first, then the instruction's own destination, then the data port again. When the destination is an ordinary register, every move is sent to the hard-wired zero register, which means the burst writes nothing. The move count never exceeds the live remaining count.

Top module: `extra_move_seq`

## Requirements
- R1: After reset, `inReady` is 1 and `mvValid` is 0.
- R2: An instruction is accepted on a rising edge where `inValid` and `inReady` are both 1. It produces exactly M = min(`inCount`, `remCount`) moves.
- R3: If M is 0, no move is issued and `inReady` stays 1 in the following cycle.
- R4: If M is 1 or 2 and `inDst` is at least SPECIAL_BASE (0x1D), every move has `mvDst` = DATA_IDX (0x1D) and `mvData` = the captured `inSrc2`.
- R5: If M is 3 and `inDst` is at least 0x1D, the moves go to DATA_IDX, then the captured `inDst`, then DATA_IDX. All three carry the captured `inSrc2`.
- R6: If `inDst` is below 0x1D, every move of the burst has `mvDst` = 0, including the middle move of a three-move burst.
- R7: `inReady` is 0 from the cycle after an accepting edge with M > 0 until the cycle after the edge on which the last move is taken.
- R8: The first move is valid in the cycle after acceptance. A move with `mvReady` low stays presented with the same `mvDst` and `mvData`. When `mvReady` stays high, each move is valid for exactly one cycle.
- R9: Changes on `inDst`, `inSrc2`, `inCount` and `remCount` after acceptance do not alter the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | ALU instruction with modifier presented |
| inReady | output | 1 | Issue stage may present the next instruction |
| inCount | input | 2 | Requested extra moves N (0 to 3) |
| remCount | input | REM_W (8) | Live remaining-count register value |
| inDst | input | IDX_W (5) | Decoded destination index of the ALU instruction |
| inSrc2 | input | DATA_W (32) | Second-source operand value |
| mvValid | output | 1 | A move micro-operation is presented |
| mvReady | input | 1 | Consumer takes the presented move |
| mvDst | output | IDX_W (5) | Destination index of the presented move |
| mvData | output | DATA_W (32) | Value written by the presented move |

## Verification
Several properties are checked on every cycle. Issue is held off while a move is presented. A stalled move keeps its destination and data. The step index stays inside the clipped count. An instruction clipped to zero moves opens no burst. Only the bench's scenarios can show the rest: that the number of moves equals min(N, rem) for each mix of inputs, the exact destination order of the three-move burst for special and ordinary destinations, and that inputs changed mid-burst leave it untouched. The bench also measures how many cycles the issue stage stays stalled, with and without back-pressure.

// File: rtl/emseq_pkg.sv
package emseq_pkg;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic [CNT_W-1:0] step;
  } emseq_strobe_t;
endpackage

// File: rtl/emseq_datapath.sv
module emseq_datapath
  import emseq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 5,
  parameter int REM_W        = 8,
  parameter int SPECIAL_BASE = 29,
  parameter int DATA_IDX     = 29,
  parameter int ZERO_IDX     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  emseq_strobe_t     strobe,
  input  logic [CNT_W-1:0]  inCount,
  input  logic [REM_W-1:0]  remCount,
  input  logic [IDX_W-1:0]  inDst,
  input  logic [DATA_W-1:0] inSrc2,
  input  logic              mvValid,
  input  logic              mvReady,
  output logic [CNT_W-1:0]  clipCnt,
  output logic [CNT_W-1:0]  totCnt,
  output logic [IDX_W-1:0]  mvDst,
  output logic [DATA_W-1:0] mvData
);
  localparam logic [IDX_W-1:0] SPECIAL_LO = IDX_W'(SPECIAL_BASE);
  localparam logic [IDX_W-1:0] DATA_SEL   = IDX_W'(DATA_IDX);
  localparam logic [IDX_W-1:0] ZERO_SEL   = IDX_W'(ZERO_IDX);
  localparam logic [CNT_W-1:0] FULL_BURST = '1;
  localparam logic [CNT_W-1:0] MID_STEP   = CNT_W'(1);

  logic [IDX_W-1:0]  dstR;
  logic [DATA_W-1:0] dataR;

  // Clip the requested count against the live remaining count.
  always_comb begin
    if (remCount < REM_W'(inCount)) clipCnt = remCount[CNT_W-1:0];
    else                             clipCnt = inCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstR   <= '0;
      dataR  <= '0;
      totCnt <= '0;
    end else if (strobe.load) begin
      dstR   <= inDst;
      dataR  <= inSrc2;
      totCnt <= clipCnt;
    end
  end

  // Destination select for the move currently presented.
  always_comb begin
    if (dstR < SPECIAL_LO)
      mvDst = ZERO_SEL;
    else if (totCnt == FULL_BURST && strobe.step == MID_STEP)
      mvDst = dstR;
    else
      mvDst = DATA_SEL;
  end

  assign mvData = dataR;

  // R8: a move held by back-pressure keeps destination and data.
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    mvValid && !mvReady |=> mvValid && $stable(mvDst) && $stable(mvData));
endmodule

// File: rtl/emseq_ctrl.sv
module emseq_ctrl
  import emseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CNT_W-1:0] clipCnt,
  input  logic [CNT_W-1:0] totCnt,
  input  logic             mvReady,
  output logic             inReady,
  output logic             mvValid,
  output emseq_strobe_t    strobe
);
  logic             busyR;
  logic [CNT_W-1:0] stepR;
  logic             accept;
  logic             lastStep;

  assign accept   = inValid && !busyR;
  assign lastStep = (stepR == totCnt - CNT_W'(1));

  assign inReady        = !busyR;
  assign mvValid        = busyR;
  assign strobe.load    = accept && (clipCnt != '0);
  assign strobe.advance = busyR && mvReady;
  assign strobe.step    = stepR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      stepR <= '0;
    end else if (strobe.load) begin
      busyR <= 1'b1;
      stepR <= '0;
    end else if (strobe.advance) begin
      if (lastStep) busyR <= 1'b0;
      else          stepR <= stepR + CNT_W'(1);
    end
  end

  // R7: issue stays closed whenever a move is presented.
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rstN)
    mvValid |-> !inReady);

  // R3: an instruction clipped to zero moves opens no burst.
  a_r3_zero_no_burst: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && clipCnt == '0 |=> !mvValid && inReady);

  // R2: the step index never reaches the clipped total.
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    mvValid |-> stepR < totCnt);

  // R8: the first move follows an accepting load on the next cycle.
  a_r8_first_move: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> mvValid);
endmodule

// File: rtl/extra_move_seq.sv
module extra_move_seq
  import emseq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 5,
  parameter int REM_W        = 8,
  parameter int SPECIAL_BASE = 29,
  parameter int DATA_IDX     = 29,
  parameter int ZERO_IDX     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inCount,
  input  logic [REM_W-1:0]  remCount,
  input  logic [IDX_W-1:0]  inDst,
  input  logic [DATA_W-1:0] inSrc2,
  output logic              mvValid,
  input  logic              mvReady,
  output logic [IDX_W-1:0]  mvDst,
  output logic [DATA_W-1:0] mvData
);
  emseq_strobe_t    strobe;
  logic [CNT_W-1:0] clipCnt;
  logic [CNT_W-1:0] totCnt;

  emseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .clipCnt (clipCnt),
    .totCnt  (totCnt),
    .mvReady (mvReady),
    .inReady (inReady),
    .mvValid (mvValid),
    .strobe  (strobe)
  );

  emseq_datapath #(
    .DATA_W       (DATA_W),
    .IDX_W        (IDX_W),
    .REM_W        (REM_W),
    .SPECIAL_BASE (SPECIAL_BASE),
    .DATA_IDX     (DATA_IDX),
    .ZERO_IDX     (ZERO_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inCount  (inCount),
    .remCount (remCount),
    .inDst    (inDst),
    .inSrc2   (inSrc2),
    .mvValid  (mvValid),
    .mvReady  (mvReady),
    .clipCnt  (clipCnt),
    .totCnt   (totCnt),
    .mvDst    (mvDst),
    .mvData   (mvData)
  );
endmodule

// File: tb/extra_move_seq_tb.sv
module extra_move_seq_tb;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;
  localparam int REM_W  = 8;
  localparam logic [IDX_W-1:0] DATA_SEL = 5'h1D;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [1:0]        inCount = '0;
  logic [REM_W-1:0]  remCount = '0;
  logic [IDX_W-1:0]  inDst = '0;
  logic [DATA_W-1:0] inSrc2 = '0;
  logic              mvValid;
  logic              mvReady = 1'b1;
  logic [IDX_W-1:0]  mvDst;
  logic [DATA_W-1:0] mvData;

  int checks = 0;
  int fails  = 0;
  bit stallMode = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [IDX_W-1:0]  qDst[$];
  logic [DATA_W-1:0] qData[$];
  string             qTag[$];

  always #2.5 clk = ~clk;

  extra_move_seq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCount(inCount), .remCount(remCount), .inDst(inDst), .inSrc2(inSrc2),
    .mvValid(mvValid), .mvReady(mvReady), .mvDst(mvDst), .mvData(mvData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Back-pressure pattern on the move consumer.
  always @(negedge clk) begin
    cyc++;
    mvReady <= stallMode ? (cyc % 3 == 0) : 1'b1;
  end

  // Monitor: compare each taken move against the scoreboard.
  always @(negedge clk) begin
    #1;
    if (rstN && mvValid && mvReady) begin
      if (qDst.size() == 0) begin
        check(1'b0, "R2", "unexpected extra move dst", longint'(mvDst), 0);
      end else begin
        logic [IDX_W-1:0]  eDst;
        logic [DATA_W-1:0] eData;
        string             eTag;
        eDst = qDst.pop_front();
        eData = qData.pop_front();
        eTag = qTag.pop_front();
        check(mvDst == eDst, eTag, "move dst", longint'(mvDst), longint'(eDst));
        check(mvData == eData, eTag, "move data", longint'(mvData), longint'(eData));
      end
    end
  end

  // Driver: issue one instruction and push the expected moves.
  task automatic issue(input logic [1:0] n, input logic [REM_W-1:0] rem,
                       input logic [IDX_W-1:0] dst, input logic [DATA_W-1:0] src,
                       input string tag);
    int m;
    int stalled;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    m = (int'(rem) < int'(n)) ? int'(rem) : int'(n);
    inValid = 1'b1; inCount = n; remCount = rem; inDst = dst; inSrc2 = src;
    for (int i = 0; i < m; i++) begin
      if (dst < 5'h1D) qDst.push_back('0);             // R6
      else if (m == 3 && i == 1) qDst.push_back(dst);  // R5
      else qDst.push_back(DATA_SEL);                   // R4
      qData.push_back(src);
      qTag.push_back(tag);
    end
    @(negedge clk);
    inValid = 1'b0;
    // R9: disturb the inputs after acceptance.
    inDst = ~dst; inSrc2 = ~src; inCount = ~n; remCount = ~rem;
    if (m == 0) begin
      check(inReady == 1'b1, "R3", "ready after zero-move instr", longint'(inReady), 1);
      check(mvValid == 1'b0, "R3", "valid after zero-move instr", longint'(mvValid), 0);
    end else begin
      check(mvValid == 1'b1, "R8", "first move valid next cycle", longint'(mvValid), 1);
    end
    stalled = 0;
    while (!inReady && stalled < 40) begin
      stalled++;
      @(negedge clk);
    end
    if (!stallMode)
      check(stalled == m, "R7", "stall cycles", longint'(stalled), longint'(m));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(inReady == 1'b1, "R1", "inReady after reset", longint'(inReady), 1);
    check(mvValid == 1'b0, "R1", "mvValid after reset", longint'(mvValid), 0);

    issue(2'd0, 8'd5, 5'h1D, 32'h1111_0000, "R3");     // N = 0
    issue(2'd3, 8'd0, 5'h1E, 32'h2222_0000, "R3");     // rem = 0
    issue(2'd1, 8'd7, 5'h1D, 32'hA000_0001, "R4");     // M = 1
    issue(2'd2, 8'd9, 5'h1F, 32'hA000_0002, "R4");     // M = 2
    issue(2'd3, 8'd3, 5'h1E, 32'hB000_0003, "R5");     // M = 3, middle to dst
    issue(2'd3, 8'd200, 5'h1F, 32'hB000_0004, "R5");   // large rem
    issue(2'd3, 8'd2, 5'h1E, 32'hC000_0005, "R2");     // clipped to 2, no middle dst
    issue(2'd2, 8'd1, 5'h1D, 32'hC000_0006, "R2");     // clipped to 1
    issue(2'd3, 8'd4, 5'h05, 32'hD000_0007, "R6");     // ordinary dst, all zero
    issue(2'd2, 8'd4, 5'h1C, 32'hD000_0008, "R6");     // just below special base
    issue(2'd1, 8'd1, 5'h00, 32'hD000_0009, "R6");
    stallMode = 1'b1;
    issue(2'd3, 8'd3, 5'h1F, 32'hE000_000A, "R8");     // back-pressured burst
    issue(2'd3, 8'd3, 5'h0A, 32'hE000_000B, "R8");
    issue(2'd2, 8'd2, 5'h1D, 32'hE000_000C, "R9");
    stallMode = 1'b0;
    issue(2'd3, 8'd3, 5'h1E, 32'hF000_000D, "R9");
    repeat (6) @(negedge clk);
    #2;
    // R2: every expected move was produced
    check(qDst.size() == 0, "R2", "moves left in scoreboard", longint'(qDst.size()), 0);
    check(inReady == 1'b1 && mvValid == 1'b0, "R7", "idle at end",
          longint'({inReady, mvValid}), 2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule